// File: doc/BRIEF.md
# Running-Status MIDI Note Parser

This block takes a stream of received MIDI bytes, one byte per cycle when a valid strobe is high, and turns the Note On and Note Off messages in it into writes to a table of per-key velocities. The table covers a window of 37 consecutive keys. A key counts as held while its entry is nonzero. The envelope bank reads one bit per key from a held-key vector, and any entry can also be read back through a combinational read port.

The parser keeps a running-status buffer, so a sender may omit the status byte on repeated messages. System real-time bytes can be interleaved anywhere without disturbing a message. System common bytes cancel the current running status. Note Off, and Note On with velocity zero, both leave a zero in the table. Messages on any other status are parsed for framing and then dropped.

Top module: `midi_note_parser`

## Requirements
- R1: A synchronous active-low reset clears every table entry and the running status, so data bytes that arrive after reset and before any status byte change nothing.
- R2: A byte from 0xF8 to 0xFF leaves the running status, the pending note and the table unchanged, even in the middle of a message.
- R3: A byte from 0xF0 to 0xF7 clears the running status and the data-byte phase, and later data bytes are ignored until a new status byte arrives.
- R4: A byte from 0x80 to 0xEF becomes the running status, and the next data byte is taken as a note number, even if a message was half received.
- R5: Data bytes (bit 7 clear) have no effect while the running status is zero.
- R6: Under status 0x90, the first data byte is latched as the note number and the second is written as the velocity to key index note-36. The entry updates on the clock edge that accepts the second data byte.
- R7: After a complete pair, the parser expects a new first data byte under the same running status.
- R8: Under status 0x80, the second data byte is consumed but the value written is 0.
- R9: Only the exact status values 0x80 and 0x90 write the table. Any other status, including note messages on other channels, still frames its data pairs but writes nothing.
- R10: Notes 36 to 72 map to key indices 0 to 36. Notes outside that range write nothing.
- R11: Bit i of the held-key vector is 1 exactly when entry i is nonzero, so a Note On with velocity 0 releases the key.
- R12: The read port returns entry rd_key combinationally and returns 0 for an index of 37 or more. A read of the key being written in the same cycle returns the old value, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | byte_in carries a received byte this cycle |
| byte_in | input | 8 | Received MIDI byte |
| rd_key | input | 6 | Key index to read |
| rd_vel | output | 7 | Velocity stored for rd_key |
| key_held | output | 37 | One bit per key, set while its velocity is nonzero |

## Verification
A table write and a read of the same key can fall in the same cycle. The bench holds rd_key on a key while the velocity byte for that key is presented. It samples rd_vel just before the accepting edge, where the old value is expected, and again after that edge, where the new value is expected. A second overlap is a real-time byte arriving between the note and velocity bytes. This is judged by the later velocity still landing on the latched key.

// File: rtl/midi_note_pkg.sv
// Shared types and constants for the MIDI note parser.
// Assumes standard MIDI byte categories; only channel-1 note messages act.
package midi_note_pkg;
    typedef enum logic [1:0] {
        BC_DATA     = 2'd0,
        BC_STATUS   = 2'd1,
        BC_SYSCOM   = 2'd2,
        BC_REALTIME = 2'd3
    } byte_class_e;

    localparam logic [7:0] ST_NOTE_OFF = 8'h80;
    localparam logic [7:0] ST_NOTE_ON  = 8'h90;
endpackage

// File: rtl/midi_byte_class.sv
// Sorts one MIDI byte into data, channel status, system common or real-time.
// Purely combinational; assumes nothing about the surrounding stream.
module midi_byte_class
    import midi_note_pkg::*;
(
    input  logic [7:0]  byte_in,
    output byte_class_e cls
);
    // Classify by top bit and the system-message ranges
    always_comb begin
        if (!byte_in[7])            cls = BC_DATA;
        else if (byte_in >= 8'hF8)  cls = BC_REALTIME;
        else if (byte_in >= 8'hF0)  cls = BC_SYSCOM;
        else                        cls = BC_STATUS;
    end
endmodule

// File: rtl/midi_note_fsm.sv
// Running-status tracker and data-byte phase for note messages.
// Emits a one-cycle table write when a complete in-range note pair arrives.
// Assumes byte_in is only meaningful while byte_valid is high.
module midi_note_fsm
    import midi_note_pkg::*;
#(
    parameter int NUM_KEYS  = 37,
    parameter int BASE_NOTE = 36,
    parameter int VEL_W     = 7,
    localparam int IDX_W    = $clog2(NUM_KEYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  byte_class_e       cls,
    output logic [7:0]        run_status,
    output logic              second_pending,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [VEL_W-1:0]  wr_vel
);
    localparam logic [6:0] LO_NOTE = 7'(BASE_NOTE);
    localparam logic [7:0] HI_NOTE = 8'(BASE_NOTE + NUM_KEYS - 1);

    logic [6:0] note_q;
    logic       note_ok;
    logic       is_note_msg;

    // Track running status, data phase and latched note number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_status     <= '0;
            second_pending <= 1'b0;
            note_q         <= '0;
        end else if (byte_valid) begin
            case (cls)
                BC_REALTIME: ;
                BC_SYSCOM: begin
                    run_status     <= '0;
                    second_pending <= 1'b0;
                end
                BC_STATUS: begin
                    run_status     <= byte_in;
                    second_pending <= 1'b0;
                end
                default: begin
                    if (run_status != '0) begin
                        if (!second_pending) begin
                            note_q         <= byte_in[6:0];
                            second_pending <= 1'b1;
                        end else begin
                            second_pending <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    // Decide whether the byte now arriving completes a table write
    always_comb begin
        note_ok     = (note_q >= LO_NOTE) && ({1'b0, note_q} <= HI_NOTE);
        is_note_msg = (run_status == ST_NOTE_ON) || (run_status == ST_NOTE_OFF);
        wr_en       = byte_valid && (cls == BC_DATA) && (run_status != '0)
                      && second_pending && is_note_msg && note_ok;
        wr_idx      = IDX_W'(note_q - LO_NOTE);
        wr_vel      = (run_status == ST_NOTE_OFF) ? '0 : VEL_W'(byte_in[6:0]);
    end
endmodule

// File: rtl/key_vel_table.sv
// Per-key velocity storage with one write port and one combinational read.
// Assumes wr_idx is below NUM_KEYS whenever wr_en is high.
module key_vel_table #(
    parameter int NUM_KEYS = 37,
    parameter int VEL_W    = 7,
    localparam int IDX_W   = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [VEL_W-1:0]    wr_vel,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [VEL_W-1:0]    rd_vel,
    output logic [NUM_KEYS-1:0] held
);
    logic [VEL_W-1:0] vel_q [NUM_KEYS];

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        // Store this key's velocity on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)                                  vel_q[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))       vel_q[k] <= wr_vel;
        end
        assign held[k] = |vel_q[k];
    end

    // Select the addressed entry, zero when out of range
    always_comb begin
        rd_vel = '0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_vel = vel_q[i];
        end
    end
endmodule

// File: rtl/midi_note_parser.sv
// Top of the MIDI note parser: classifies bytes, tracks running status and
// keeps the per-key velocity table read by the envelope bank.
// Assumes at most one byte per cycle, presented with byte_valid.
module midi_note_parser
    import midi_note_pkg::*;
#(
    parameter int NUM_KEYS  = 37,
    parameter int BASE_NOTE = 36,
    parameter int VEL_W     = 7,
    localparam int IDX_W    = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_valid,
    input  logic [7:0]          byte_in,
    input  logic [IDX_W-1:0]    rd_key,
    output logic [VEL_W-1:0]    rd_vel,
    output logic [NUM_KEYS-1:0] key_held
);
    byte_class_e      cls;
    logic [7:0]       run_status;
    logic             second_pending;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [VEL_W-1:0] wr_vel;

    midi_byte_class u_class (
        .byte_in (byte_in),
        .cls     (cls)
    );

    midi_note_fsm #(
        .NUM_KEYS  (NUM_KEYS),
        .BASE_NOTE (BASE_NOTE),
        .VEL_W     (VEL_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .byte_valid     (byte_valid),
        .byte_in        (byte_in),
        .cls            (cls),
        .run_status     (run_status),
        .second_pending (second_pending),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_vel         (wr_vel)
    );

    key_vel_table #(
        .NUM_KEYS (NUM_KEYS),
        .VEL_W    (VEL_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_vel (wr_vel),
        .rd_idx (rd_key),
        .rd_vel (rd_vel),
        .held   (key_held)
    );
endmodule

// File: rtl/midi_note_parser_chk.sv
// Protocol checker for the MIDI note parser, bound to the top module.
module midi_note_parser_chk #(
    parameter int NUM_KEYS = 37
) (
    input logic                clk,
    input logic                rst_n,
    input logic                byte_valid,
    input logic [7:0]          byte_in,
    input logic [7:0]          run_status,
    input logic                second_pending,
    input logic [NUM_KEYS-1:0] key_held
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (key_held == '0) && (run_status == 8'h00) && !second_pending);

    assert_realtime_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_in >= 8'hF8) |=>
            $stable(run_status) && $stable(second_pending) && $stable(key_held));

    assert_syscom_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_in >= 8'hF0 && byte_in <= 8'hF7) |=>
            (run_status == 8'h00) && !second_pending);

    assert_status_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_in >= 8'h80 && byte_in <= 8'hEF) |=>
            (run_status == $past(byte_in)) && !second_pending);

    assert_orphan_data_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_in[7] && run_status == 8'h00) |=>
            $stable(second_pending) && $stable(key_held));

    assert_single_key_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(key_held ^ $past(key_held)) <= 1);
endmodule

bind midi_note_parser midi_note_parser_chk #(.NUM_KEYS(NUM_KEYS)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid     (byte_valid),
    .byte_in        (byte_in),
    .run_status     (run_status),
    .second_pending (second_pending),
    .key_held       (key_held)
);

// File: tb/midi_note_parser_tb_top.sv
`timescale 1ns/1ps
module midi_note_parser_tb_top;
    localparam int NK = 37;
    localparam int NV = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_in = '0;
    logic [5:0]    rd_key = '0;
    logic [6:0]    rd_vel;
    logic [NK-1:0] key_held;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    midi_note_parser dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .rd_key(rd_key), .rd_vel(rd_vel), .key_held(key_held)
    );

    // {req, byte, read index, expected velocity after the byte}
    localparam logic [24:0] VEC [NV] = '{
        {4'd5,  8'h3C, 6'd24, 7'd0},   // R5 data before any status
        {4'd4,  8'h90, 6'd24, 7'd0},   // R4 note-on status
        {4'd6,  8'h3C, 6'd24, 7'd0},   // R6 note 60 latched
        {4'd6,  8'h64, 6'd24, 7'd100}, // R6 velocity written
        {4'd7,  8'h40, 6'd28, 7'd0},   // R7 running status note 64
        {4'd2,  8'hF8, 6'd28, 7'd0},   // R2 real-time mid message
        {4'd2,  8'h20, 6'd28, 7'd32},  // R2 pair completes after it
        {4'd10, 8'h24, 6'd0,  7'd0},   // R10 lowest note
        {4'd10, 8'h7F, 6'd0,  7'd127},
        {4'd10, 8'h48, 6'd36, 7'd0},   // R10 highest note
        {4'd10, 8'h01, 6'd36, 7'd1},
        {4'd10, 8'h49, 6'd36, 7'd1},   // R10 note 73 out of range
        {4'd10, 8'h55, 6'd36, 7'd1},
        {4'd10, 8'h23, 6'd0,  7'd127}, // R10 note 35 out of range
        {4'd10, 8'h55, 6'd0,  7'd127},
        {4'd8,  8'h80, 6'd24, 7'd100}, // R8 note-off status
        {4'd8,  8'h3C, 6'd24, 7'd100},
        {4'd8,  8'h40, 6'd24, 7'd0},
        {4'd8,  8'h40, 6'd28, 7'd32},
        {4'd8,  8'h7F, 6'd28, 7'd0},
        {4'd11, 8'h90, 6'd0,  7'd127}, // R11 note-on velocity 0
        {4'd11, 8'h24, 6'd0,  7'd127},
        {4'd11, 8'h00, 6'd0,  7'd0},
        {4'd4,  8'h90, 6'd12, 7'd0},   // R4 status restarts a message
        {4'd4,  8'h30, 6'd12, 7'd0},
        {4'd4,  8'hB0, 6'd12, 7'd0},
        {4'd9,  8'h30, 6'd12, 7'd0},   // R9 controller status ignored
        {4'd9,  8'h10, 6'd12, 7'd0},
        {4'd3,  8'h90, 6'd12, 7'd0},   // R3 system common cancels
        {4'd3,  8'h30, 6'd12, 7'd0},
        {4'd3,  8'hF3, 6'd12, 7'd0},
        {4'd3,  8'h50, 6'd12, 7'd0},
        {4'd3,  8'h30, 6'd12, 7'd0},
        {4'd9,  8'h91, 6'd12, 7'd0},   // R9 other channel ignored
        {4'd9,  8'h30, 6'd12, 7'd0},
        {4'd9,  8'h40, 6'd12, 7'd0}
    };

    task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one byte for one cycle; returns at the following falling edge
    task automatic send(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state while held in reset
        check(1, 64'(key_held), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        rd_key = 6'd0;
        check(1, 64'(rd_vel), 64'(0));

        for (int i = 0; i < NV; i++) begin
            rd_key = VEC[i][12:7];
            send(VEC[i][20:13]);
            check(int'(VEC[i][24:21]), 64'(rd_vel), 64'(VEC[i][6:0]));
        end

        // R11 only key 36 still holds a velocity
        check(11, 64'(key_held), 64'(37'(1) << 36));

        // R12 out-of-range read index returns zero
        rd_key = 6'd40;
        #1 check(12, 64'(rd_vel), 64'(0));
        rd_key = 6'd36;
        #1 check(12, 64'(rd_vel), 64'(1));

        // R12 write and read of the same key in one cycle
        @(negedge clk);
        rd_key = 6'd24;
        send(8'h90);
        send(8'h3C);
        byte_valid = 1'b1;
        byte_in    = 8'h55;
        #1 check(12, 64'(rd_vel), 64'(0));
        @(negedge clk);
        byte_valid = 1'b0;
        check(12, 64'(rd_vel), 64'(8'h55));

        // R1 reset mid-run clears table and running status
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, 64'(key_held), 64'(0));
        send(8'h3C);
        send(8'h40);
        check(1, 64'(key_held), 64'(0));

        done = 1'b1;
        finish_run();
    end
endmodule